// File: doc/BRIEF.md
# Display Frame CRC32 Monitor

This block watches the stream of 32-bit pixel words that a display controller sends out of its parallel pixel port and forms one CRC32 signature per frame. Software or a safety checker compares that signature with a value computed from the frame buffer. A match shows that the displayed frame is intact. Frames are marked by a start-of-frame strobe and an end-of-frame strobe. The valid strobe says which cycles carry a word.

Each word is folded into the running CRC in a single clock. At the end of the frame the finished signature is latched into a status register that can only be read. A one-cycle done pulse follows, and the engine reseeds for the next frame. A separate underflow input is held in a sticky flag for the length of the frame and latched beside the signature. A frame whose pixel supply was starved is flagged this way, even when its CRC appears to match.

Top module: `fcrc_monitor`

## Requirements
- R1: While reset is asserted and after its release, `sig_value` reads 0, and `sig_underflow` and `crc_done` read 0 until the first end-of-frame.
- R2: The signature equals an MSB-first CRC with generator 0x04C11DB7, initial value 0xFFFFFFFF and no final XOR, over the frame's words in the order sent. Bit 31 of each word is fed first. This is the same as a reflected 0xEDB88320 engine fed bit-reversed words, whose result is bit-reversed at the end.
- R3: A cycle with `pix_valid` low leaves the running CRC unchanged, so idle gaps inside a frame do not alter the signature.
- R4: On a cycle with `pix_eof` high, the signature takes in that cycle's word if `pix_valid` is high. It appears on `sig_value` after that clock edge, with `crc_done` high for exactly that one following cycle. `sig_value` then holds until the next end-of-frame.
- R5: After an end-of-frame the running CRC is reseeded to 0xFFFFFFFF. A following frame is correct whether or not it starts with `pix_sof`.
- R6: `pix_sof` reseeds the CRC before that cycle's word is folded in, which discards any partial frame in progress.
- R7: A minimum frame of 8 pixels by 2 lines (16 words) yields the correct signature.
- R8: `underflow_in` high on any cycle of a frame, from its `pix_sof` cycle through its `pix_eof` cycle, makes `sig_underflow` read 1 with that frame's signature. The flag is cleared for the next frame, and `pix_sof` also clears it.
- R9: A frame closed by `pix_eof` with `pix_valid` low covers only the earlier words. A frame with no valid words (for example `pix_sof` and `pix_eof` in the same cycle with `pix_valid` low) gives 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| pix_valid | input | 1 | Word on pix_data is part of the frame |
| pix_data | input | 32 | Pixel word as sent on the pixel port |
| pix_sof | input | 1 | First cycle of a frame; reseeds the CRC |
| pix_eof | input | 1 | Last cycle of a frame; latches the signature |
| underflow_in | input | 1 | Pixel supply starved during this cycle |
| sig_value | output | 32 | Latched signature of the last completed frame |
| sig_underflow | output | 1 | Last completed frame saw an underflow |
| crc_done | output | 1 | One-cycle pulse after a signature is latched |

## Verification
The bench goes after the bit order first. An engine that folded words without reversing them, or that applied the customary final inversion, would produce a plausible but wrong signature on every random frame. It also targets words that arrive on the end-of-frame cycle and frames closed with valid low. A design that dropped or double-counted those words would be off by one word. Back-to-back frames and a start-of-frame strobe in mid-frame expose a missing reseed, which would chain one frame's CRC into the next. Underflow pulses on the first cycle, on the last cycle and in the middle of a frame, each followed by a clean frame, show whether the sticky flag is caught, latched and cleared at the right edge.

// File: rtl/fcrc_pkg.sv
package fcrc_pkg;
  localparam int unsigned FCRC_W = 32;
  typedef logic [FCRC_W-1:0] crc_word_t;
  localparam crc_word_t FCRC_POLY_REFL = 32'hEDB88320;
  localparam crc_word_t FCRC_SEED      = 32'hFFFFFFFF;

  typedef struct packed {
    crc_word_t value;
    logic      underflow;
  } frame_sig_t;
endpackage

// File: rtl/fcrc_bit_reverse.sv
module fcrc_bit_reverse #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_rev
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/fcrc_fold.sv
// Unrolled reflected CRC update: DATA_W input bits, lowest bit first.
module fcrc_fold #(
  parameter int unsigned CRC_W  = 32,
  parameter int unsigned DATA_W = 32,
  parameter logic [CRC_W-1:0] POLY = 32'hEDB88320
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] stage [DATA_W+1];

  assign stage[0] = crc_in;

  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic fb;
    assign fb           = stage[i][0] ^ data_in[i];
    assign stage[i+1]   = (stage[i] >> 1) ^ ({CRC_W{fb}} & POLY);
  end

  assign crc_out = stage[DATA_W];
endmodule

// File: rtl/fcrc_frame_seq.sv
// Frame sequencing: running CRC register, sticky underflow, status latch.
module fcrc_frame_seq
  import fcrc_pkg::*;
#(
  parameter crc_word_t SEED = FCRC_SEED
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pix_valid,
  input  logic       pix_sof,
  input  logic       pix_eof,
  input  logic       underflow_in,
  input  crc_word_t  folded,
  input  crc_word_t  final_rev,
  output crc_word_t  fold_base,
  output crc_word_t  word_result,
  output crc_word_t  run_crc,
  output frame_sig_t status,
  output logic       done
);
  crc_word_t  crc_q, crc_d;
  logic       uf_q, uf_d;
  logic       uf_frame;
  frame_sig_t stat_q, stat_d;
  logic       stat_en;
  logic       done_q, done_d;

  // next-state
  always_comb begin
    fold_base   = pix_sof ? SEED : crc_q;
    word_result = pix_valid ? folded : fold_base;
    uf_frame    = (pix_sof ? 1'b0 : uf_q) | underflow_in;
    stat_en     = pix_eof;
    stat_d      = '{value: final_rev, underflow: uf_frame};
    done_d      = pix_eof;
    if (pix_eof) begin
      crc_d = SEED;
      uf_d  = 1'b0;
    end else begin
      crc_d = word_result;
      uf_d  = uf_frame;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q  <= SEED;
      uf_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      crc_q  <= crc_d;
      uf_q   <= uf_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  assign run_crc = crc_q;
  assign status  = stat_q;
  assign done    = done_q;
endmodule

// File: rtl/fcrc_monitor.sv
module fcrc_monitor
  import fcrc_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter crc_word_t   POLY   = FCRC_POLY_REFL,
  parameter crc_word_t   SEED   = FCRC_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              pix_sof,
  input  logic              pix_eof,
  input  logic              underflow_in,
  output logic [FCRC_W-1:0] sig_value,
  output logic              sig_underflow,
  output logic              crc_done
);
  logic [DATA_W-1:0] data_rev;
  crc_word_t         fold_base, folded, word_result, final_rev, run_crc;
  frame_sig_t        status;

  fcrc_bit_reverse #(.W(DATA_W)) u_in_rev (
    .din (pix_data),
    .dout(data_rev)
  );

  fcrc_fold #(.CRC_W(FCRC_W), .DATA_W(DATA_W), .POLY(POLY)) u_fold (
    .crc_in (fold_base),
    .data_in(data_rev),
    .crc_out(folded)
  );

  fcrc_bit_reverse #(.W(FCRC_W)) u_out_rev (
    .din (word_result),
    .dout(final_rev)
  );

  fcrc_frame_seq #(.SEED(SEED)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .pix_valid   (pix_valid),
    .pix_sof     (pix_sof),
    .pix_eof     (pix_eof),
    .underflow_in(underflow_in),
    .folded      (folded),
    .final_rev   (final_rev),
    .fold_base   (fold_base),
    .word_result (word_result),
    .run_crc     (run_crc),
    .status      (status),
    .done        (crc_done)
  );

  assign sig_value     = status.value;
  assign sig_underflow = status.underflow;
endmodule

// File: rtl/fcrc_monitor_chk.sv
module fcrc_monitor_chk #(
  parameter logic [31:0] SEED = 32'hFFFFFFFF
) (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_valid,
  input logic        pix_sof,
  input logic        pix_eof,
  input logic        underflow_in,
  input logic [31:0] sig_value,
  input logic        sig_underflow,
  input logic        crc_done,
  input logic [31:0] run_crc
);
  a_r4_done_after_eof: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eof |=> crc_done);

  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_eof |=> !crc_done);

  a_r4_sig_held: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_eof |=> $stable(sig_value) && $stable(sig_underflow));

  a_r5_reseed: assert property (@(posedge clk) disable iff (!rst_n)
    pix_eof |=> run_crc == SEED);

  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_valid && !pix_sof && !pix_eof) |=> $stable(run_crc));

  a_r8_uf_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_eof && underflow_in) |=> sig_underflow);

  a_r9_empty_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_eof && pix_sof && !pix_valid) |=> sig_value == SEED);
endmodule

bind fcrc_monitor fcrc_monitor_chk #(.SEED(SEED)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .pix_valid    (pix_valid),
  .pix_sof      (pix_sof),
  .pix_eof      (pix_eof),
  .underflow_in (underflow_in),
  .sig_value    (sig_value),
  .sig_underflow(sig_underflow),
  .crc_done     (crc_done),
  .run_crc      (run_crc)
);

// File: tb/fcrc_monitor_tb_top.sv
`timescale 1ns/1ps
module fcrc_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic        pix_sof = 1'b0;
  logic        pix_eof = 1'b0;
  logic        underflow_in = 1'b0;
  logic [31:0] sig_value;
  logic        sig_underflow;
  logic        crc_done;

  always #10 clk = ~clk;  // 50 MHz

  fcrc_monitor dut_i (
    .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_sof(pix_sof), .pix_eof(pix_eof), .underflow_in(underflow_in),
    .sig_value(sig_value), .sig_underflow(sig_underflow), .crc_done(crc_done)
  );

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    finished = 1'b0;

  // Reference: MSB-first CRC, generator 0x04C11DB7, init all ones, no final XOR.
  function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C11DB7;
    end
    return r;
  endfunction

  logic [31:0] m_crc, exp_sig;
  bit          m_uf, exp_uf, exp_done;

  always @(posedge clk or negedge rst_n) begin
    logic [31:0] c;
    bit          u;
    if (!rst_n) begin
      m_crc = 32'hFFFFFFFF; m_uf = 0; exp_sig = '0; exp_uf = 0; exp_done = 0;
    end else begin
      c = pix_sof ? 32'hFFFFFFFF : m_crc;
      if (pix_valid) c = ref_step(c, pix_data);
      u = (pix_sof ? 1'b0 : m_uf) | underflow_in;
      if (pix_eof) begin
        exp_sig = c; exp_uf = u; exp_done = 1;
        m_crc = 32'hFFFFFFFF; m_uf = 0;
      end else begin
        exp_done = 0; m_crc = c; m_uf = u;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      n_checks++;
      if (sig_value !== exp_sig || sig_underflow !== exp_uf || crc_done !== exp_done) begin
        n_fail++;
        $display("FAIL %s: actual sig=%08h uf=%0b done=%0b expected sig=%08h uf=%0b done=%0b",
                 cur_req, sig_value, sig_underflow, crc_done, exp_sig, exp_uf, exp_done);
      end
    end
  end

  task automatic drive(bit v, logic [31:0] d, bit s, bit e, bit u);
    @(posedge clk); #5;
    pix_valid = v; pix_data = d; pix_sof = s; pix_eof = e; underflow_in = u;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, $urandom, 0, 0, 0);
  endtask

  // Frame of n words; gap_pct chance of an idle cycle before each word;
  // uf_idx selects a word index that carries an underflow (-1 for none).
  task automatic frame(int n, int gap_pct, int uf_idx, bit with_sof);
    for (int i = 0; i < n; i++) begin
      if (i > 0 && ($urandom % 100) < gap_pct) drive(0, $urandom, 0, 0, 0);
      drive(1, $urandom, with_sof && i == 0, i == n - 1, i == uf_idx);
    end
  endtask

  task automatic direct_check(string req, bit ok, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    cmp_on = 1'b1;
    cur_req = "R1";
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    idle(3);
    @(negedge clk);
    direct_check("R1", sig_value == 0 && !crc_done && !sig_underflow, sig_value, 32'h0);

    cur_req = "R7"; frame(16, 0, -1, 1); idle(2);
    cur_req = "R3"; frame(20, 60, -1, 1); idle(2);
    cur_req = "R5";
    frame(10, 0, -1, 1); frame(10, 0, -1, 1); frame(7, 20, -1, 0); idle(2);
    cur_req = "R6";
    frame(9, 0, -1, 1);
    for (int i = 0; i < 5; i++) drive(1, $urandom, i == 0, 0, 0);
    frame(6, 0, -1, 1); idle(2);
    cur_req = "R8";
    frame(12, 10, 5, 1); frame(12, 10, -1, 1);
    frame(8, 0, 0, 1); frame(8, 0, 7, 1); frame(8, 0, -1, 1);
    drive(0, 0, 0, 0, 1); frame(6, 0, -1, 1); idle(2);
    cur_req = "R9";
    for (int i = 0; i < 4; i++) drive(1, $urandom, i == 0, 0, 0);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 1, 1, 0);
    idle(1);
    @(negedge clk);
    direct_check("R9", sig_value == 32'hFFFFFFFF, sig_value, 32'hFFFFFFFF);
    cur_req = "R4"; frame(5, 0, -1, 1); idle(20);
    cur_req = "R2";
    for (int f = 0; f < 40; f++)
      frame(1 + ($urandom % 40), $urandom % 50,
            (($urandom % 4) == 0) ? int'($urandom % 8) : -1, ($urandom % 5) != 0);
    idle(3);
    @(negedge clk);
    cmp_on = 1'b0;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule